// File: doc/BRIEF.md
# Drive Status and Event Register Pair

This block holds two 16-bit status words for a drive controller. The event word is sticky. A condition pulse, one cycle wide, raises its bit, and the bit stays high until a masked clear command removes it or reset is asserted. The drive word is live. Its bits follow level condition inputs, and each input is registered once on the way in.

Several output-disabling fault sources share one sticky drive-exception bit. These sources are a bus voltage fault, a watchdog timeout, an overcurrent, and a falling edge on the enable input. A read strobe with a select line returns one of the two words on the next clock. The value returned is the word as it stood before any clear issued in that same cycle. Command decoding, the serial link and fault-pin logic are handled elsewhere.

Top module: `drv_status_regs`

## Requirements
- R1: An event bit that has been set stays 1 on every later cycle until a clear command or reset removes it.
- R2: When clr_i is high at a clock edge, event bits at positions where clr_mask_i is 0 become 0. Bits at positions where the mask is 1 keep their value.
- R3: A pulse on instr_err_i sets event bit 7.
- R4: A pulse on ovt_fault_i sets event bit 9, and a pulse on fold_evt_i sets event bit 12.
- R5: Event bit 10 is set by a pulse on bus_volt_i, wdog_i or ocur_i, and by a 1-to-0 transition of enable_i. Holding enable_i low, and a 0-to-1 transition of enable_i, set nothing.
- R6: Event bits 0-6, 8, 11 and 13-15 always read as 0.
- R7: Drive word bit 1 is in_fold_i, bit 2 is ovt_cond_i, bit 4 is holding_i and bit 5 is ovolt_i, each as sampled at the previous clock edge. Every other drive word bit reads 0. The drive word has no effect on the event word.
- R8: If an event pulse and a clear of the same bit occur at the same clock edge, the bit ends up 1.
- R9: While rst_ni is low, all event bits and rd_data_o are 0.
- R10: When rd_i is high at a clock edge, rd_data_o takes the selected word from that edge onward. rd_sel_i = 0 selects the event word and rd_sel_i = 1 selects the drive word. The event value returned is the one held before any clear at the same edge. Without rd_i, rd_data_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_err_i | input | 1 | Instruction error pulse |
| ovt_fault_i | input | 1 | Overtemperature fault pulse |
| fold_evt_i | input | 1 | Current foldback event pulse |
| bus_volt_i | input | 1 | Bus voltage fault pulse |
| wdog_i | input | 1 | Watchdog timeout pulse |
| ocur_i | input | 1 | Overcurrent pulse |
| enable_i | input | 1 | Output enable level; a falling edge is a drive exception |
| in_fold_i | input | 1 | Currently in foldback |
| ovt_cond_i | input | 1 | Currently overtemperature |
| holding_i | input | 1 | Currently at holding current |
| ovolt_i | input | 1 | Currently overvoltage |
| clr_i | input | 1 | Event clear command |
| clr_mask_i | input | 16 | Clear mask; 0 bits are cleared |
| rd_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Read select: 0 event word, 1 drive word |
| rd_data_o | output | 16 | Registered read data |

## Verification
The assertions assume that enable_i does not change while reset is asserted. They also assume that every input is stable across a clock edge. The stimulus meets both assumptions by driving all inputs at falling clock edges and by leaving enable_i high through reset. The enable-edge property assumes that enable_i is high in the first cycle after reset. Each directed scenario therefore starts from a state in which enable_i is high, and it returns enable_i to high before it ends.

// File: rtl/drv_status_pkg.sv
package drv_status_pkg;
  localparam int unsigned STAT_W = 16;

  // event word positions
  localparam int unsigned EV_INSTR = 7;
  localparam int unsigned EV_OVT   = 9;
  localparam int unsigned EV_DRVX  = 10;
  localparam int unsigned EV_FOLD  = 12;

  // drive word positions
  localparam int unsigned DS_FOLD  = 1;
  localparam int unsigned DS_OVT   = 2;
  localparam int unsigned DS_HOLD  = 4;
  localparam int unsigned DS_OVOLT = 5;

  typedef logic [STAT_W-1:0] stat_word_t;

  localparam stat_word_t EV_USED = (stat_word_t'(1) << EV_INSTR) | (stat_word_t'(1) << EV_OVT)
                                 | (stat_word_t'(1) << EV_DRVX)  | (stat_word_t'(1) << EV_FOLD);
  localparam stat_word_t DS_USED = (stat_word_t'(1) << DS_FOLD) | (stat_word_t'(1) << DS_OVT)
                                 | (stat_word_t'(1) << DS_HOLD) | (stat_word_t'(1) << DS_OVOLT);

  typedef enum logic {
    RD_EVT = 1'b0,
    RD_DRV = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/stat_evt_src.sv
module stat_evt_src
  import drv_status_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       instr_err_i,
  input  logic       ovt_fault_i,
  input  logic       fold_evt_i,
  input  logic       bus_volt_i,
  input  logic       wdog_i,
  input  logic       ocur_i,
  input  logic       enable_i,
  output stat_word_t set_o
);
  logic en_q;
  logic en_fall;
  logic drvx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= enable_i;
  end

  assign en_fall = en_q & ~enable_i;
  assign drvx    = bus_volt_i | wdog_i | ocur_i | en_fall;

  always_comb begin
    set_o           = '0;
    set_o[EV_INSTR] = instr_err_i;
    set_o[EV_OVT]   = ovt_fault_i;
    set_o[EV_DRVX]  = drvx;
    set_o[EV_FOLD]  = fold_evt_i;
  end
endmodule

// File: rtl/stat_evt_reg.sv
module stat_evt_reg #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         USED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] keep;
  assign keep = clr_i ? clr_mask_i : '1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= USED[i] ? ((q_o[i] & keep[i]) | set_i[i]) : 1'b0; // set beats clear
    end
  end
endmodule

// File: rtl/stat_live_reg.sv
module stat_live_reg #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= cond_i & USED;
  end
endmodule

// File: rtl/stat_rd_port.sv
module stat_rd_port
  import drv_status_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  rd_sel_e    sel_i,
  input  stat_word_t evt_i,
  input  stat_word_t drv_i,
  output stat_word_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (rd_i) data_o <= (sel_i == RD_DRV) ? drv_i : evt_i;
  end
endmodule

// File: rtl/drv_status_regs.sv
module drv_status_regs
  import drv_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_err_i,
  input  logic              ovt_fault_i,
  input  logic              fold_evt_i,
  input  logic              bus_volt_i,
  input  logic              wdog_i,
  input  logic              ocur_i,
  input  logic              enable_i,
  input  logic              in_fold_i,
  input  logic              ovt_cond_i,
  input  logic              holding_i,
  input  logic              ovolt_i,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  input  logic              rd_i,
  input  logic              rd_sel_i,
  output logic [STAT_W-1:0] rd_data_o
);
  stat_word_t evt_set;
  stat_word_t evt_q;
  stat_word_t drv_cond;
  stat_word_t drv_q;

  stat_evt_src u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .instr_err_i (instr_err_i),
    .ovt_fault_i (ovt_fault_i),
    .fold_evt_i  (fold_evt_i),
    .bus_volt_i  (bus_volt_i),
    .wdog_i      (wdog_i),
    .ocur_i      (ocur_i),
    .enable_i    (enable_i),
    .set_o       (evt_set)
  );

  stat_evt_reg #(.W(STAT_W), .USED(EV_USED)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (evt_set),
    .clr_i      (clr_i),
    .clr_mask_i (clr_mask_i),
    .q_o        (evt_q)
  );

  always_comb begin
    drv_cond           = '0;
    drv_cond[DS_FOLD]  = in_fold_i;
    drv_cond[DS_OVT]   = ovt_cond_i;
    drv_cond[DS_HOLD]  = holding_i;
    drv_cond[DS_OVOLT] = ovolt_i;
  end

  stat_live_reg #(.W(STAT_W), .USED(DS_USED)) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (drv_cond),
    .q_o    (drv_q)
  );

  stat_rd_port u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .sel_i  (rd_sel_e'(rd_sel_i)),
    .evt_i  (evt_q),
    .drv_i  (drv_q),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/drv_status_regs_chk.sv
module drv_status_regs_chk
  import drv_status_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       instr_err_i,
  input logic       ovt_fault_i,
  input logic       fold_evt_i,
  input logic       wdog_i,
  input logic       enable_i,
  input logic       in_fold_i,
  input logic       ovolt_i,
  input logic       clr_i,
  input stat_word_t clr_mask_i,
  input logic       rd_i,
  input logic       rd_sel_i,
  input stat_word_t rd_data_o,
  input stat_word_t evt_q,
  input stat_word_t drv_q
);
  a_r1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  a_r2_mask_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((evt_q & $past(evt_q & clr_mask_i)) == $past(evt_q & clr_mask_i)));

  a_r3_instr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_err_i |=> evt_q[EV_INSTR]);

  a_r4_fault_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovt_fault_i && fold_evt_i) |=> (evt_q[EV_OVT] && evt_q[EV_FOLD]));

  a_r5_enable_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(enable_i) || wdog_i) |=> evt_q[EV_DRVX]);

  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~(EV_USED | DS_USED)) == '0);

  a_r7_live_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drv_q[DS_FOLD] == $past(in_fold_i)) && (drv_q[DS_OVOLT] == $past(ovolt_i)));

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_err_i && clr_i && !clr_mask_i[EV_INSTR]) |=> evt_q[EV_INSTR]);

  a_r10_read_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rd_sel_i) |=> rd_data_o == $past(evt_q));

  a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
endmodule

bind drv_status_regs drv_status_regs_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_err_i (instr_err_i),
  .ovt_fault_i (ovt_fault_i),
  .fold_evt_i  (fold_evt_i),
  .wdog_i      (wdog_i),
  .enable_i    (enable_i),
  .in_fold_i   (in_fold_i),
  .ovolt_i     (ovolt_i),
  .clr_i       (clr_i),
  .clr_mask_i  (clr_mask_i),
  .rd_i        (rd_i),
  .rd_sel_i    (rd_sel_i),
  .rd_data_o   (rd_data_o),
  .evt_q       (evt_q),
  .drv_q       (drv_q)
);

// File: tb/drv_status_regs_tb_top.sv
`timescale 1ns/1ps
module drv_status_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_err_i = 0, ovt_fault_i = 0, fold_evt_i = 0;
  logic        bus_volt_i = 0, wdog_i = 0, ocur_i = 0, enable_i = 1;
  logic        in_fold_i = 0, ovt_cond_i = 0, holding_i = 0, ovolt_i = 0;
  logic        clr_i = 0;
  logic [15:0] clr_mask_i = 16'hFFFF;
  logic        rd_i = 0, rd_sel_i = 0;
  logic [15:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  drv_status_regs dut_i (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_word(input logic sel, output logic [15:0] val);
    @(negedge clk_i); rd_i = 1; rd_sel_i = sel;
    @(negedge clk_i); rd_i = 0; val = rd_data_o;
  endtask

  task automatic clear(input logic [15:0] m);
    @(negedge clk_i); clr_i = 1; clr_mask_i = m;
    @(negedge clk_i); clr_i = 0; clr_mask_i = 16'hFFFF;
  endtask

  // 0 instr, 1 ovt, 2 fold, 3 bus, 4 wdog, 5 ocur
  task automatic fire(input int src);
    @(negedge clk_i);
    case (src)
      0: instr_err_i = 1;  1: ovt_fault_i = 1;  2: fold_evt_i = 1;
      3: bus_volt_i = 1;   4: wdog_i = 1;       default: ocur_i = 1;
    endcase
    @(negedge clk_i);
    {instr_err_i, ovt_fault_i, fold_evt_i, bus_volt_i, wdog_i, ocur_i} = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R9 rd_data in reset", rd_data_o, 16'h0000);
    @(negedge clk_i); rst_ni = 1;
    rd_word(0, v); check("R9 event word after reset", v, 16'h0000);
  endtask

  task automatic t_sources;
    logic [15:0] v;
    fire(0); rd_word(0, v); check("R3 instr err bit 7", v, 16'h0080);
    repeat (3) @(negedge clk_i);
    rd_word(0, v); check("R1 bit 7 sticky", v, 16'h0080);
    fire(1); rd_word(0, v); check("R4 ovt fault bit 9", v, 16'h0280);
    fire(2); rd_word(0, v); check("R4 foldback bit 12", v, 16'h1280);
    check("R6 reserved event bits zero", v & 16'h E97F, 16'h0000);
    clear(16'h0000);
    for (int s = 3; s < 6; s++) begin
      fire(s); rd_word(0, v); check("R5 drive exception source", v, 16'h0400);
      clear(16'h0000);
    end
  endtask

  task automatic t_enable;
    logic [15:0] v;
    @(negedge clk_i); enable_i = 0;
    rd_word(0, v); check("R5 enable fall sets bit 10", v, 16'h0400);
    clear(16'hFBFF);
    repeat (2) @(negedge clk_i);
    rd_word(0, v); check("R5 enable held low no event", v, 16'h0000);
    @(negedge clk_i); enable_i = 1;
    rd_word(0, v); check("R5 enable rise no event", v, 16'h0000);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    fire(0); fire(1); fire(2);
    clear(16'hFDFF);
    rd_word(0, v); check("R2 mask zero clears bit 9 only", v, 16'h1080);
    clear(16'hFFFF);
    rd_word(0, v); check("R2 all-ones mask keeps", v, 16'h1080);
    clear(16'h0000);
  endtask

  task automatic t_set_wins;
    logic [15:0] v;
    fire(1);
    @(negedge clk_i); instr_err_i = 1; clr_i = 1; clr_mask_i = 16'h0000;
    @(negedge clk_i); instr_err_i = 0; clr_i = 0; clr_mask_i = 16'hFFFF;
    rd_word(0, v); check("R8 set beats clear", v, 16'h0080);
  endtask

  task automatic t_read_clear;
    logic [15:0] v;
    fire(1);
    @(negedge clk_i); rd_i = 1; rd_sel_i = 0; clr_i = 1; clr_mask_i = 16'h0000;
    @(negedge clk_i); rd_i = 0; clr_i = 0; clr_mask_i = 16'hFFFF;
    check("R10 read returns pre-clear word", rd_data_o, 16'h0280);
    fire(2);
    repeat (2) @(negedge clk_i);
    check("R10 output holds without read", rd_data_o, 16'h0280);
    rd_word(0, v); check("R10 later read sees cleared+new", v, 16'h1000);
    clear(16'h0000);
  endtask

  task automatic t_live;
    logic [15:0] v;
    @(negedge clk_i); in_fold_i = 1; holding_i = 1;
    rd_word(1, v); check("R7 fold and holding", v, 16'h0012);
    @(negedge clk_i); ovt_cond_i = 1; ovolt_i = 1;
    rd_word(1, v); check("R7 all conditions", v, 16'h0036);
    @(negedge clk_i); {in_fold_i, ovt_cond_i, holding_i, ovolt_i} = '0;
    rd_word(1, v); check("R7 conditions cleared", v, 16'h0000);
    rd_word(0, v); check("R7 event word untouched", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_sources();
    t_enable();
    t_mask();
    t_set_wins();
    t_read_clear();
    t_live();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule